// File: doc/BRIEF.md
# Paged Switch Register Access Bridge

This bridge gives a host a plain 32-bit register port onto an Ethernet switch whose registers can only be reached through 16-bit management transactions. Each host request names one switch register address. The bridge turns it into three transactions on a simple request/done port that feeds an MDIO master. The first transaction writes a page number. The second and third move the two 16-bit halves of the data word. For a read, the bridge joins the halves into one 32-bit result; for a write, it splits the host word into two halves.

The page number is the part of the address above bit 8. The PHY and register numbers for the two half transfers come from the lower address bits. A model-select input picks which of two switch variants is attached. The variant sets where the page register lives and whether one special address needs its write halves in reverse order. The bridge handles one request at a time. If any transaction reports an error, the sequence stops at that point and the error is returned with the completion.

Top module: `swreg_bridge`

## Requirements
- R1: The first transaction after a request is accepted is always a write. Its data is the request address shifted right by 9, zero-extended to 16 bits.
- R2: The page write goes to PHY 0x1F, register 0x10 when model_sel is 0, and to PHY 0x18, register 0x00 when model_sel is 1.
- R3: Both half transfers use PHY number 0x10 OR address bits 8:6. Their register number is address bits 5:2 placed in bits 4:1, with bit 0 = 1 selecting the high half and bit 0 = 0 the low half.
- R4: A read fetches the low half first and the high half second. It completes with rsp_rdata = {high half, low half}.
- R5: A write sends data bits 31:16 to the high-half register first and bits 15:0 to the low-half register second.
- R6: When model_sel is 0 and the address equals 0x98, a write sends the low half first and the high half second. With model_sel 1, address 0x98 keeps the R5 order.
- R7: If mdio_done arrives with mdio_err high, no further transaction is issued. The request completes with rsp_valid and rsp_err both high, and rsp_rdata is zero.
- R8: req_ready is high only when no request is in progress. While it is low, req_valid and the request fields are ignored.
- R9: rsp_valid is a single-cycle pulse for each accepted request. rsp_rdata is zero except during the completion of a read that had no error.
- R10: While rst_n is low, and for the first cycles after it rises, req_ready, mdio_req and rsp_valid are low. Within three cycles after release, req_ready goes high.
- R11: mdio_req is a single-cycle pulse. The next transaction is issued only after mdio_done has been seen for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Switch register address |
| req_wdata | input | 32 | Write data |
| model_sel | input | 1 | Switch variant select |
| rsp_valid | output | 1 | Completion pulse |
| rsp_err | output | 1 | Completion ended by a transaction error |
| rsp_rdata | output | 32 | Read result |
| mdio_req | output | 1 | Start one management transaction |
| mdio_write | output | 1 | Transaction is a write |
| mdio_phy | output | 5 | Transaction PHY number |
| mdio_reg | output | 5 | Transaction register number |
| mdio_wdata | output | 16 | Transaction write data |
| mdio_done | input | 1 | Transaction finished |
| mdio_err | input | 1 | Transaction failed (valid with mdio_done) |
| mdio_rdata | input | 16 | Transaction read data (valid with mdio_done) |

## Verification
The bench builds the bridge with its default 18-bit address and the default page locations and reordered address. This makes the full 9-bit page range, all eight derived PHY numbers and all sixteen register pairs reachable through random addresses. The responder varies its latency from one to four cycles and injects errors at each of the three steps. This shows that the abort happens at the failing step and that the reordered write applies to only one model. A request held valid through a busy period shows that changed fields are ignored.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    STEP_PAGE   = 2'd0,
    STEP_FIRST  = 2'd1,
    STEP_SECOND = 2'd2
  } seq_step_e;

  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ID_W   = 5;

  typedef struct packed {
    logic              write;
    logic [ID_W-1:0]   phy;
    logic [ID_W-1:0]   regn;
    logic [HALF_W-1:0] wdata;
  } mdio_cmd_t;

endpackage

// File: rtl/swreg_addr_map.sv
module swreg_addr_map
  import swreg_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 18,
  parameter logic [ID_W-1:0]  PAGE_PHY_A = 5'h1F,
  parameter logic [ID_W-1:0]  PAGE_REG_A = 5'h10,
  parameter logic [ID_W-1:0]  PAGE_PHY_B = 5'h18,
  parameter logic [ID_W-1:0]  PAGE_REG_B = 5'h00,
  parameter logic [ADDR_W-1:0] SWAP_ADDR = 'h98
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              model_sel,
  output logic [ID_W-1:0]   page_phy,
  output logic [ID_W-1:0]   page_reg,
  output logic [HALF_W-1:0] page_wdata,
  output logic [ID_W-1:0]   data_phy,
  output logic [ID_W-1:0]   data_reg_base,
  output logic              lo_first
);
  localparam int unsigned PAGE_LSB = 9;
  localparam int unsigned PAGE_W   = ADDR_W - PAGE_LSB;

  // page register location per switch variant
  always_comb begin
    if (model_sel) begin
      page_phy = PAGE_PHY_B;
      page_reg = PAGE_REG_B;
    end else begin
      page_phy = PAGE_PHY_A;
      page_reg = PAGE_REG_A;
    end
  end

  always_comb begin
    page_wdata = '0;
    page_wdata[PAGE_W-1:0] = addr[ADDR_W-1:PAGE_LSB];
  end

  assign data_phy      = {2'b10, addr[8:6]};
  assign data_reg_base = {addr[5:2], 1'b0};

  // reads and the reordered write go low half first
  assign lo_first = !write || (!model_sel && (addr == SWAP_ADDR));

endmodule

// File: rtl/swreg_seq.sv
module swreg_seq
  import swreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      mdio_done,
  input  logic      mdio_err,
  output logic      ready,
  output logic      accept,
  output logic      issue,
  output seq_step_e step,
  output logic      cap_en,
  output logic      rsp_valid,
  output logic      rsp_err
);
  seq_state_e state_q, state_d;
  seq_step_e  step_q, step_d;
  logic       err_q, err_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_ISSUE;
          step_d  = STEP_PAGE;
          err_d   = 1'b0;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mdio_done) begin
          if (mdio_err) begin
            err_d   = 1'b1;
            state_d = ST_RESP;
          end else if (step_q == STEP_SECOND) begin
            state_d = ST_RESP;
          end else begin
            state_d = ST_ISSUE;
            step_d  = (step_q == STEP_PAGE) ? STEP_FIRST : STEP_SECOND;
          end
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= STEP_PAGE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      err_q   <= err_d;
    end
  end

  assign ready     = (state_q == ST_IDLE);
  assign accept    = ready && req_valid;
  assign issue     = (state_q == ST_ISSUE);
  assign step      = step_q;
  assign cap_en    = (state_q == ST_WAIT) && mdio_done && !mdio_err && (step_q != STEP_PAGE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_err   = rsp_valid && err_q;

endmodule

// File: rtl/swreg_datapath.sv
module swreg_datapath
  import swreg_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 18,
  parameter logic [ID_W-1:0]   PAGE_PHY_A = 5'h1F,
  parameter logic [ID_W-1:0]   PAGE_REG_A = 5'h10,
  parameter logic [ID_W-1:0]   PAGE_PHY_B = 5'h18,
  parameter logic [ID_W-1:0]   PAGE_REG_B = 5'h00,
  parameter logic [ADDR_W-1:0] SWAP_ADDR  = 'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              model_sel,
  input  seq_step_e         step,
  input  logic              cap_en,
  input  logic [HALF_W-1:0] mdio_rdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output mdio_cmd_t         cmd,
  output logic [WORD_W-1:0] rsp_rdata
);
  localparam int unsigned NUM_HALVES = WORD_W / HALF_W;

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              write_q;
  logic              model_q;
  logic [WORD_W-1:0] rd_q;

  logic [ID_W-1:0]   page_phy, page_reg, data_phy, data_reg_base;
  logic [HALF_W-1:0] page_wdata;
  logic              lo_first;
  logic              half_hi;

  // request capture, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      model_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      model_q <= model_sel;
    end
  end

  swreg_addr_map #(
    .ADDR_W    (ADDR_W),
    .PAGE_PHY_A(PAGE_PHY_A),
    .PAGE_REG_A(PAGE_REG_A),
    .PAGE_PHY_B(PAGE_PHY_B),
    .PAGE_REG_B(PAGE_REG_B),
    .SWAP_ADDR (SWAP_ADDR)
  ) u_map (
    .addr         (addr_q),
    .write        (write_q),
    .model_sel    (model_q),
    .page_phy     (page_phy),
    .page_reg     (page_reg),
    .page_wdata   (page_wdata),
    .data_phy     (data_phy),
    .data_reg_base(data_reg_base),
    .lo_first     (lo_first)
  );

  // which half the current data step moves
  assign half_hi = (step == STEP_FIRST) ? !lo_first : lo_first;

  always_comb begin
    if (step == STEP_PAGE) begin
      cmd.write = 1'b1;
      cmd.phy   = page_phy;
      cmd.regn  = page_reg;
      cmd.wdata = page_wdata;
    end else begin
      cmd.write = write_q;
      cmd.phy   = data_phy;
      cmd.regn  = data_reg_base | {{(ID_W-1){1'b0}}, half_hi};
      cmd.wdata = wdata_q[(half_hi ? HALF_W : 0) +: HALF_W];
    end
  end

  // read assembly, one register slice per half
  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    logic slice_en;
    assign slice_en = cap_en && (half_hi == g[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q[g*HALF_W +: HALF_W] <= '0;
      end else if (accept) begin
        rd_q[g*HALF_W +: HALF_W] <= '0;
      end else if (slice_en) begin
        rd_q[g*HALF_W +: HALF_W] <= mdio_rdata;
      end
    end
  end

  assign rsp_rdata = (rsp_valid && !rsp_err && !write_q) ? rd_q : '0;

endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge
  import swreg_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 18,
  parameter logic [4:0]        PAGE_PHY_A = 5'h1F,
  parameter logic [4:0]        PAGE_REG_A = 5'h10,
  parameter logic [4:0]        PAGE_PHY_B = 5'h18,
  parameter logic [4:0]        PAGE_REG_B = 5'h00,
  parameter logic [ADDR_W-1:0] SWAP_ADDR  = 'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              model_sel,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              mdio_req,
  output logic              mdio_write,
  output logic [4:0]        mdio_phy,
  output logic [4:0]        mdio_reg,
  output logic [15:0]       mdio_wdata,
  input  logic              mdio_done,
  input  logic              mdio_err,
  input  logic [15:0]       mdio_rdata
);
  logic      rst_meta_q, rst_sync_n;
  logic      seq_ready, accept, cap_en;
  seq_step_e step;
  mdio_cmd_t cmd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  swreg_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_valid(req_valid),
    .mdio_done(mdio_done),
    .mdio_err (mdio_err),
    .ready    (seq_ready),
    .accept   (accept),
    .issue    (mdio_req),
    .step     (step),
    .cap_en   (cap_en),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err)
  );

  swreg_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_PHY_A(PAGE_PHY_A),
    .PAGE_REG_A(PAGE_REG_A),
    .PAGE_PHY_B(PAGE_PHY_B),
    .PAGE_REG_B(PAGE_REG_B),
    .SWAP_ADDR (SWAP_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .model_sel (model_sel),
    .step      (step),
    .cap_en    (cap_en),
    .mdio_rdata(mdio_rdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .cmd       (cmd),
    .rsp_rdata (rsp_rdata)
  );

  assign req_ready  = seq_ready && rst_sync_n;
  assign mdio_write = cmd.write;
  assign mdio_phy   = cmd.phy;
  assign mdio_reg   = cmd.regn;
  assign mdio_wdata = cmd.wdata;

endmodule

// File: rtl/swreg_bridge_chk.sv
module swreg_bridge_chk #(
  parameter int unsigned ADDR_W     = 18,
  parameter logic [4:0]  PAGE_PHY_A = 5'h1F,
  parameter logic [4:0]  PAGE_REG_A = 5'h10,
  parameter logic [4:0]  PAGE_PHY_B = 5'h18,
  parameter logic [4:0]  PAGE_REG_B = 5'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              model_sel,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic              mdio_req,
  input logic              mdio_write,
  input logic [4:0]        mdio_phy,
  input logic [4:0]        mdio_reg,
  input logic [15:0]       mdio_wdata,
  input logic              mdio_done
);
  AST_PAGE_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mdio_req && mdio_write && (mdio_wdata == 16'($past(req_addr) >> 9)))); // R1

  AST_PAGE_LOC_A: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !model_sel) |=> (mdio_phy == PAGE_PHY_A && mdio_reg == PAGE_REG_A)); // R2

  AST_PAGE_LOC_B: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && model_sel) |=> (mdio_phy == PAGE_PHY_B && mdio_reg == PAGE_REG_B)); // R2

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R7

  AST_RSP_AFTER_MDIO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mdio_done)); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req || rsp_valid) |-> !req_ready); // R8

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == '0)); // R9

  AST_MDIO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |=> !mdio_req); // R11

endmodule

bind swreg_bridge swreg_bridge_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_PHY_A(PAGE_PHY_A),
  .PAGE_REG_A(PAGE_REG_A),
  .PAGE_PHY_B(PAGE_PHY_B),
  .PAGE_REG_B(PAGE_REG_B)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .model_sel (model_sel),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .mdio_req  (mdio_req),
  .mdio_write(mdio_write),
  .mdio_phy  (mdio_phy),
  .mdio_reg  (mdio_reg),
  .mdio_wdata(mdio_wdata),
  .mdio_done (mdio_done)
);

// File: tb/swreg_bridge_bench.sv
`timescale 1ns/1ps
module swreg_bridge_bench;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              model_sel = 1'b0;
  logic              rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic              mdio_req, mdio_write;
  logic [4:0]        mdio_phy, mdio_reg;
  logic [15:0]       mdio_wdata;
  logic              mdio_done = 1'b0;
  logic              mdio_err = 1'b0;
  logic [15:0]       mdio_rdata = '0;

  always #4 clk = ~clk;

  swreg_bridge u_swreg_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .model_sel(model_sel), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mdio_req(mdio_req), .mdio_write(mdio_write),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
    .mdio_done(mdio_done), .mdio_err(mdio_err), .mdio_rdata(mdio_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // responder state
  int          lat_g = 1;
  int          err_g = -1;
  logic [15:0] salt_g = '0;
  int          lg_n = 0;
  logic        lg_w[0:7];
  logic [4:0]  lg_phy[0:7];
  logic [4:0]  lg_reg[0:7];
  logic [15:0] lg_wd[0:7];
  bit          overlap = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [15:0] resp_fn(input logic [4:0] phy, input logic [4:0] rg,
                                          input logic [15:0] salt);
    return {phy[2:0], rg, 3'b101, rg ^ 5'h1B} ^ salt;
  endfunction

  // MDIO-side responder
  initial begin
    @(negedge clk);
    forever begin
      if (mdio_req) begin
        if (lg_n < 8) begin
          lg_w[lg_n]   = mdio_write;
          lg_phy[lg_n] = mdio_phy;
          lg_reg[lg_n] = mdio_reg;
          lg_wd[lg_n]  = mdio_wdata;
        end
        for (int k = 0; k < lat_g; k++) begin
          @(negedge clk);
          if (mdio_req) overlap = 1;
        end
        mdio_done  = 1'b1;
        mdio_err   = (lg_n == err_g);
        mdio_rdata = resp_fn(mdio_phy, mdio_reg, salt_g);
        lg_n++;
        @(negedge clk);
        mdio_done  = 1'b0;
        mdio_err   = 1'b0;
        mdio_rdata = '0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic do_req(input logic [ADDR_W-1:0] a, input bit w, input logic [31:0] wd,
                        input bit m, input int lat, input int e, input bit hold);
    bit          lo_first, swap, hi;
    logic [4:0]  ephy[0:2];
    logic [4:0]  ereg[0:2];
    logic [15:0] ewd[0:2];
    logic        ew[0:2];
    int          ecount;
    logic [31:0] erd;
    logic        got_err, got_ready;
    logic [31:0] got_rd;
    string       otag;
    lat_g = lat; err_g = e; salt_g = 16'($urandom); lg_n = 0; overlap = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = wd; model_sel = m;
    @(negedge clk);
    if (hold) begin
      req_addr = a ^ 18'h155; req_write = !w; req_wdata = ~wd; model_sel = !m;
    end else begin
      req_valid = 1'b0;
    end
    while (!rsp_valid) @(negedge clk);
    got_err = rsp_err; got_rd = rsp_rdata; got_ready = req_ready;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rsp_valid, "R9", "completion pulse width", 32'(rsp_valid), 0);
    chk(!got_ready, "R8", "ready during completion", 32'(got_ready), 0);
    chk(!overlap, "R11", "request issued before done", 32'(overlap), 0);

    // expected sequence from the requirements
    swap     = !m && (a == 18'h98);
    lo_first = !w || swap;
    otag     = !w ? "R4" : (swap ? "R6" : "R5");
    ew[0] = 1'b1; ephy[0] = m ? 5'h18 : 5'h1F; ereg[0] = m ? 5'h00 : 5'h10;
    ewd[0] = 16'(a >> 9);
    for (int k = 1; k < 3; k++) begin
      hi = (k == 1) ? !lo_first : lo_first;
      ew[k] = w; ephy[k] = {2'b10, a[8:6]}; ereg[k] = {a[5:2], hi};
      ewd[k] = hi ? wd[31:16] : wd[15:0];
    end
    ecount = (e < 0) ? 3 : e + 1;
    erd = (!w && e < 0) ? {resp_fn(ephy[1], {a[5:2], 1'b1}, salt_g),
                           resp_fn(ephy[1], {a[5:2], 1'b0}, salt_g)} : 32'h0;

    chk(lg_n == ecount, (e < 0) ? otag : "R7", "transaction count", 32'(lg_n), 32'(ecount));
    chk(got_err == (e >= 0), "R7", "error flag", 32'(got_err), 32'(e >= 0));
    chk(got_rd == erd, w ? "R9" : "R4", "read result", got_rd, erd);
    for (int k = 0; k < 3; k++) begin
      if (k < lg_n && k < ecount) begin
        if (k == 0) begin
          chk(lg_w[0] == 1'b1 && lg_wd[0] == ewd[0], "R1", "page write data",
              {15'h0, lg_w[0], lg_wd[0]}, {16'h1, ewd[0]});
          chk(lg_phy[0] == ephy[0] && lg_reg[0] == ereg[0], "R2", "page location",
              {22'h0, lg_phy[0], lg_reg[0]}, {22'h0, ephy[0], ereg[0]});
        end else begin
          chk(lg_phy[k] == ephy[k], "R3", "derived phy", 32'(lg_phy[k]), 32'(ephy[k]));
          chk(lg_reg[k] == ereg[k], otag, "half register order", 32'(lg_reg[k]), 32'(ereg[k]));
          chk(lg_w[k] == ew[k], otag, "half direction", 32'(lg_w[k]), 32'(ew[k]));
          if (w) chk(lg_wd[k] == ewd[k], otag, "half write data", 32'(lg_wd[k]), 32'(ewd[k]));
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!req_ready && !mdio_req && !rsp_valid, "R10", "outputs during reset",
        {29'h0, req_ready, mdio_req, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R10", "ready held after release", 32'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk(req_ready && !mdio_req && !rsp_valid && rsp_rdata == 0, "R10", "idle after reset",
        {29'h0, req_ready, mdio_req, rsp_valid}, 32'h4);

    // directed corners
    do_req(18'h98, 1, 32'hA1B2C3D4, 0, 1, -1, 0);   // R6 reordered write
    do_req(18'h98, 1, 32'h11223344, 1, 2, -1, 0);   // R5 other model keeps order
    do_req(18'h98, 0, 32'h0, 0, 1, -1, 0);          // R4 read at reordered address
    do_req(18'h40, 1, 32'hDEADBEEF, 0, 3, -1, 0);   // R5
    do_req(18'h10C, 0, 32'h0, 1, 4, -1, 0);         // R4
    do_req(18'h3FFFF, 0, 32'h0, 0, 1, -1, 0);       // R1 full page
    do_req(18'h3FFFF, 1, 32'hFFFF0000, 1, 1, -1, 0);
    do_req(18'h0, 1, 32'h0000FFFF, 0, 2, -1, 0);
    for (int s = 0; s < 3; s++) begin
      do_req(18'h1234 + 18'(s), 1, 32'hCAFEF00D, 0, 2, s, 0); // R7 each step
      do_req(18'h2468 + 18'(s), 0, 32'h0, 1, 1, s, 0);        // R7 on reads
    end
    do_req(18'h21C, 1, 32'h5A5A1234, 0, 3, -1, 1);  // R8 held valid ignored
    do_req(18'h98, 0, 32'h0, 1, 2, -1, 1);          // R8

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      int e;
      a = ($urandom % 6 == 0) ? 18'h98 : 18'($urandom);
      e = ($urandom % 8 == 0) ? int'($urandom % 3) : -1;
      do_req(a, 1'($urandom), $urandom, 1'($urandom), 1 + int'($urandom % 4), e, 1'($urandom % 10 == 0));
    end
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

endmodule